// File: doc/BRIEF.md
# Strobe-Reloaded Watchdog Timer

This block is a software watchdog driven by a 32.768 kHz timebase. The timebase arrives as a one-cycle enable pulse in the system clock domain. A free-running prescaler divides it by 1024 into a 32 Hz tick that decrements a 6-bit down-counter. A second divider turns the 32 Hz tick into a 1 Hz tick for timekeeping logic elsewhere on the chip.

Software writes a reload value into a load register. It restarts the countdown by writing the same port with the strobe bit set. The strobe bit clears itself, so one write gives exactly one reload. If software stops strobing, the counter reaches zero and a sticky expiry flag is set. The flag stays set until software clears it with a write. The interrupt request follows the flag only while the interrupt enable is high, main power is good and the power-up recall has finished. A load value of zero parks the watchdog.

Top module: `strobe_watchdog`

## Requirements
- R1: After reset, the counter reads 0, the expiry flag is 0, the interrupt is 0 and the 1 Hz tick is 0.
- R2: The counter decrements once for every 1024 cycles in which `oscTick` is high, counted from reset. While `oscTick` stays low, the counter holds its value.
- R3: `secTick` is high for exactly one `oscTick` cycle per 32 decrement ticks, in the cycle of every 32nd tick counted from reset.
- R4: A write with `wrEn`=1 always stores `wrLoad` in the load register. When `wrStrobe` is also 1, the counter takes the new load value on the clock edge after the write. A write with `wrStrobe`=0 leaves the counter unchanged.
- R5: The strobe clears itself after one cycle. After a reload, the counter goes on decrementing from the loaded value.
- R6: When a tick takes the counter from 1 to 0, the expiry flag is set on that edge. The counter then stays at 0 until the next reload.
- R7: While the load register holds 0, the counter does not decrement and the expiry flag is never set. This holds even when the counter is non-zero.
- R8: The expiry flag stays set until a write with `wrClearFlag`=1. If a set and a clear fall on the same edge, the set wins.
- R9: `irqOut` is 1 exactly when the expiry flag, `intEnable`, `powerGood` and `recallDone` are all 1. Losing main power or an unfinished recall forces it to 0 without changing the flag.
- R10: The load value is 6 bits wide, so the longest period is 63 ticks, and loading 63 counts down from 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| oscTick | input | 1 | One-cycle pulse at the 32.768 kHz rate |
| wrEn | input | 1 | Register write enable |
| wrLoad | input | 6 | Reload value written with every write |
| wrStrobe | input | 1 | Reload request bit of the write |
| wrClearFlag | input | 1 | Expiry-flag clear bit of the write |
| intEnable | input | 1 | Interrupt enable level |
| powerGood | input | 1 | High while on main power, low on backup power |
| recallDone | input | 1 | High once the power-up recall has finished |
| wdCount | output | 6 | Current counter value |
| wdFlag | output | 1 | Sticky expiry flag |
| irqOut | output | 1 | Gated interrupt request |
| secTick | output | 1 | 1 Hz one-cycle tick |

## Verification
The assertions check five rules on every cycle. The counter holds when no timebase pulse and no reload is pending. The counter never leaves zero without a reload. The flag only rises on a 1-to-0 step of the counter, and it survives any cycle without a clear. The interrupt stays low on backup power or before recall completes. The bench scenarios are the only place to see tick rates. They show that a decrement comes every 1024 pulses and a seconds tick every 32 decrements, that the reload lands one edge after the write, and that writing zero parks a running counter.

// File: rtl/swdt_pkg.sv
package swdt_pkg;
  // Strobes sent by the control to the datapath each cycle
  typedef struct packed {
    logic reload;     // copy load register into counter
    logic decrement;  // count down by one
  } swdtCtl_t;
endpackage

// File: rtl/swdt_prescaler.sv
module swdt_prescaler #(
  parameter int OSC_DIV = 1024,
  parameter int SEC_DIV = 32
) (
  input  logic clk,
  input  logic rstN,
  input  logic oscTick,
  output logic wdTick,
  output logic secTick
);
  localparam int PRE_W = $clog2(OSC_DIV);
  localparam int SEC_W = $clog2(SEC_DIV);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(OSC_DIV - 1);
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_DIV - 1);

  logic [PRE_W-1:0] preCnt;
  logic [SEC_W-1:0] secCnt;

  assign wdTick  = oscTick && (preCnt == PRE_LAST);
  assign secTick = wdTick && (secCnt == SEC_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (oscTick) begin
      preCnt <= wdTick ? '0 : preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secCnt <= '0;
    end else if (wdTick) begin
      secCnt <= secTick ? '0 : secCnt + 1'b1;
    end
  end
endmodule

// File: rtl/swdt_datapath.sv
module swdt_datapath
  import swdt_pkg::*;
#(
  parameter int LOAD_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadWrite,
  input  logic [LOAD_W-1:0] loadData,
  input  swdtCtl_t          ctl,
  output logic [LOAD_W-1:0] count,
  output logic              countIsZero,
  output logic              countIsOne,
  output logic              loadIsZero
);
  logic [LOAD_W-1:0] loadQ;
  logic [LOAD_W-1:0] countQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadQ <= '0;
    end else if (loadWrite) begin
      loadQ <= loadData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (ctl.reload) begin
      countQ <= loadQ;
    end else if (ctl.decrement) begin
      countQ <= countQ - 1'b1;
    end
  end

  assign count       = countQ;
  assign countIsZero = (countQ == '0);
  assign countIsOne  = (countQ == LOAD_W'(1));
  assign loadIsZero  = (loadQ == '0);
endmodule

// File: rtl/swdt_control.sv
module swdt_control
  import swdt_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     wdTick,
  input  logic     wrEn,
  input  logic     wrStrobe,
  input  logic     wrClearFlag,
  input  logic     intEnable,
  input  logic     powerGood,
  input  logic     recallDone,
  input  logic     countIsZero,
  input  logic     countIsOne,
  input  logic     loadIsZero,
  output swdtCtl_t ctl,
  output logic     flag,
  output logic     irq
);
  logic strobeQ;
  logic setFlag;
  logic clrFlag;

  // Strobe bit: set by a write, gone one cycle later
  always_ff @(posedge clk) begin
    if (!rstN) strobeQ <= 1'b0;
    else       strobeQ <= wrEn && wrStrobe;
  end

  always_comb begin
    ctl.reload    = strobeQ;
    ctl.decrement = wdTick && !strobeQ && !countIsZero && !loadIsZero;
  end

  assign setFlag = ctl.decrement && countIsOne;
  assign clrFlag = wrEn && wrClearFlag;

  always_ff @(posedge clk) begin
    if (!rstN)        flag <= 1'b0;
    else if (setFlag) flag <= 1'b1;
    else if (clrFlag) flag <= 1'b0;
  end

  assign irq = flag && intEnable && powerGood && recallDone;
endmodule

// File: rtl/strobe_watchdog.sv
module strobe_watchdog
  import swdt_pkg::*;
#(
  parameter int OSC_DIV = 1024,
  parameter int SEC_DIV = 32,
  parameter int LOAD_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              oscTick,
  input  logic              wrEn,
  input  logic [LOAD_W-1:0] wrLoad,
  input  logic              wrStrobe,
  input  logic              wrClearFlag,
  input  logic              intEnable,
  input  logic              powerGood,
  input  logic              recallDone,
  output logic [LOAD_W-1:0] wdCount,
  output logic              wdFlag,
  output logic              irqOut,
  output logic              secTick
);
  swdtCtl_t ctl;
  logic wdTick;
  logic countIsZero;
  logic countIsOne;
  logic loadIsZero;

  swdt_prescaler #(.OSC_DIV(OSC_DIV), .SEC_DIV(SEC_DIV)) pre (
    .clk(clk), .rstN(rstN), .oscTick(oscTick),
    .wdTick(wdTick), .secTick(secTick)
  );

  swdt_control ctrl (
    .clk(clk), .rstN(rstN), .wdTick(wdTick),
    .wrEn(wrEn), .wrStrobe(wrStrobe), .wrClearFlag(wrClearFlag),
    .intEnable(intEnable), .powerGood(powerGood), .recallDone(recallDone),
    .countIsZero(countIsZero), .countIsOne(countIsOne), .loadIsZero(loadIsZero),
    .ctl(ctl), .flag(wdFlag), .irq(irqOut)
  );

  swdt_datapath #(.LOAD_W(LOAD_W)) dp (
    .clk(clk), .rstN(rstN), .loadWrite(wrEn), .loadData(wrLoad), .ctl(ctl),
    .count(wdCount), .countIsZero(countIsZero), .countIsOne(countIsOne),
    .loadIsZero(loadIsZero)
  );
endmodule

// File: rtl/swdt_checker.sv
module swdt_checker #(
  parameter int LOAD_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              oscTick,
  input logic              wrEn,
  input logic              wrStrobe,
  input logic              wrClearFlag,
  input logic              powerGood,
  input logic              recallDone,
  input logic [LOAD_W-1:0] wdCount,
  input logic              wdFlag,
  input logic              irqOut
);
  // R2: no timebase pulse and no pending reload -> counter holds
  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!oscTick && !$past(wrEn && wrStrobe)) |=> $stable(wdCount));

  // R6: zero is left only through a reload
  assert_zero_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wdCount == '0 && !$past(wrEn && wrStrobe)) |=> (wdCount == '0));

  // R6/R7: flag rises only on a 1 -> 0 step
  assert_flag_rise_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdFlag) |-> (wdCount == '0 && $past(wdCount) == LOAD_W'(1)));

  // R8: flag is sticky without a clear
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wdFlag && !(wrEn && wrClearFlag)) |=> wdFlag);

  // R9: no interrupt on backup power or before recall
  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!powerGood || !recallDone) |-> !irqOut);
endmodule

bind strobe_watchdog swdt_checker #(.LOAD_W(LOAD_W)) chk (
  .clk(clk), .rstN(rstN), .oscTick(oscTick), .wrEn(wrEn), .wrStrobe(wrStrobe),
  .wrClearFlag(wrClearFlag), .powerGood(powerGood), .recallDone(recallDone),
  .wdCount(wdCount), .wdFlag(wdFlag), .irqOut(irqOut)
);

// File: tb/strobe_watchdog_test.sv
module strobe_watchdog_test;
  localparam int DIV = 1024;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic oscTick = 1'b0;
  logic wrEn = 1'b0;
  logic [5:0] wrLoad = '0;
  logic wrStrobe = 1'b0;
  logic wrClearFlag = 1'b0;
  logic intEnable = 1'b0;
  logic powerGood = 1'b1;
  logic recallDone = 1'b1;
  logic [5:0] wdCount;
  logic wdFlag;
  logic irqOut;
  logic secTick;

  int checks = 0;
  int errors = 0;
  int oscSeen = 0;
  int totalTicks = 0;
  int secSeen = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  strobe_watchdog uut (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .wrEn(wrEn), .wrLoad(wrLoad),
    .wrStrobe(wrStrobe), .wrClearFlag(wrClearFlag), .intEnable(intEnable),
    .powerGood(powerGood), .recallDone(recallDone), .wdCount(wdCount),
    .wdFlag(wdFlag), .irqOut(irqOut), .secTick(secTick)
  );

  typedef struct packed {
    logic [5:0] load;
    logic [7:0] ticks;
    logic [5:0] expCount;
    logic       expFlag;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{load: 6'd5,  ticks: 8'd2, expCount: 6'd3,  expFlag: 1'b0},
    '{load: 6'd3,  ticks: 8'd3, expCount: 6'd0,  expFlag: 1'b1},
    '{load: 6'd1,  ticks: 8'd1, expCount: 6'd0,  expFlag: 1'b1},
    '{load: 6'd0,  ticks: 8'd4, expCount: 6'd0,  expFlag: 1'b0},
    '{load: 6'd63, ticks: 8'd1, expCount: 6'd62, expFlag: 1'b0}
  };

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  // Drive oscTick until n decrement ticks have occurred (1024 pulses each)
  task automatic runTicks(input int n);
    int done = 0;
    while (done < n) begin
      @(negedge clk);
      oscTick = 1'b1;
      #1;
      if (secTick) secSeen++;
      @(posedge clk);
      oscSeen++;
      if (oscSeen % DIV == 0) begin
        done++;
        totalTicks++;
      end
    end
    @(negedge clk);
    oscTick = 1'b0;
  endtask

  // One write cycle, then one more edge so a reload has landed
  task automatic writeReg(input logic [5:0] load, input logic strobe, input logic clr);
    @(negedge clk);
    wrEn = 1'b1; wrLoad = load; wrStrobe = strobe; wrClearFlag = clr;
    @(negedge clk);
    wrEn = 1'b0; wrStrobe = 1'b0; wrClearFlag = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 count", wdCount, 0);
    check("R1 flag", wdFlag, 0);
    check("R1 irq", irqOut, 0);
    check("R1 secTick", secTick, 0);

    // Table walk: R4 reload, R2 rate, R6 expiry, R7 zero load, R10 max load
    for (int i = 0; i < 5; i++) begin
      writeReg(VECS[i].load, 1'b1, 1'b1);
      check("R4 reload", wdCount, VECS[i].load);
      runTicks(int'(VECS[i].ticks));
      check("R2/R6/R7/R10 count", wdCount, VECS[i].expCount);
      check("R6/R7 flag", wdFlag, VECS[i].expFlag);
    end

    // R2: counter holds while oscTick is low
    writeReg(6'd10, 1'b1, 1'b1);
    repeat (2000) @(negedge clk);
    check("R2 hold", wdCount, 10);

    // R4 write without strobe leaves counter; R5 counting resumes
    writeReg(6'd20, 1'b0, 1'b0);
    check("R4 no strobe", wdCount, 10);
    runTicks(1);
    check("R5 continue", wdCount, 9);
    writeReg(6'd20, 1'b1, 1'b0);
    check("R4 strobe", wdCount, 20);

    // R7: parking a running counter with load 0
    writeReg(6'd0, 1'b0, 1'b0);
    runTicks(2);
    check("R7 parked count", wdCount, 20);
    check("R7 no flag", wdFlag, 0);

    // R6/R8/R9: expiry and interrupt gating
    intEnable = 1'b1;
    writeReg(6'd1, 1'b1, 1'b0);
    check("R9 irq before expiry", irqOut, 0);
    runTicks(1);
    check("R6 flag set", wdFlag, 1);
    check("R9 irq on", irqOut, 1);
    runTicks(2);
    check("R6 zero hold", wdCount, 0);
    writeReg(6'd7, 1'b0, 1'b0);
    check("R8 sticky", wdFlag, 1);
    powerGood = 1'b0;
    #1;
    check("R9 backup power", irqOut, 0);
    check("R9 flag kept", wdFlag, 1);
    powerGood = 1'b1;
    recallDone = 1'b0;
    #1;
    check("R9 recall pending", irqOut, 0);
    recallDone = 1'b1;
    intEnable = 1'b0;
    #1;
    check("R9 disabled", irqOut, 0);
    intEnable = 1'b1;
    #1;
    check("R9 re-enabled", irqOut, 1);
    writeReg(6'd7, 1'b0, 1'b1);
    check("R8 cleared", wdFlag, 0);
    check("R8 irq dropped", irqOut, 0);

    // R3: seconds tick count over 64 decrement ticks
    writeReg(6'd0, 1'b1, 1'b1);
    if (totalTicks < 64) runTicks(64 - totalTicks);
    check("R3 sec ticks", secSeen, totalTicks / 32);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule